// File: doc/BRIEF.md
# Multibyte Register Access Coherency Unit

This block sits behind a byte-wide register bus, typically fed by a serial slave, and gives the host a coherent view of registers that are wider than one byte. Reading the lowest byte of a wide register copies the whole value into a holding register, so the upper bytes fetched afterwards belong to the same instant even if the live value keeps moving. Writes to a wide register are collected byte by byte in a staging register. The target changes in a single cycle, and only when the top byte arrives in sequence. Any access that breaks a sequence abandons it.

The block also keeps a latched event that records every change of an 8-bit status input. The host clears the event by writing a one to its bit. An enable bit masks the interrupt output without touching the latched event. The register set is an identifier that cannot be written, a 16-bit trim register, a 32-bit accumulator register, a 32-bit live hardware word, the live status byte, the event bit and the enable bit.

Top module: `mbr_coherency_unit`

## Requirements
- R1: After reset, trimOut and accumOut are zero, irqOut is low, and the event and enable bits read as zero.
- R2: A read of byte address 0x14 (lowest byte of the live word) copies the whole live word. Reads of 0x15, 0x16 and 0x17 that follow it one after another, in ascending order, return the bytes of that copy even if liveWord has changed since. A read of 0x0C followed by 0x0D to 0x0F returns the accumulator the same way.
- R3: When a read of an upper byte is not directly preceded by the in-order reads of the same register, it returns the live byte. This covers a read after an access to any other address, and an upper-byte read with no earlier lowest-byte read.
- R4: A write to the lowest byte of a writable register (trim 0x08–0x09, accumulator 0x0C–0x0F, little-endian) starts staging, and the following bytes must come in ascending order. Idle cycles between the bytes are allowed. The target and its output port keep their old value until the top byte is written, and then take the full staged value.
- R5: An out-of-order write, a write to another address, or any read during a staged write drops the staged data. The target does not change, and later writes to upper bytes have no effect until a new lowest-byte write.
- R6: Read data appears on busRdData in the clock cycle after the cycle in which busRd is high, and holds until the next read.
- R7: Any change of statusByte between two clock edges sets the event bit (bit 0 of address 0x1E) at the second edge.
- R8: Writing address 0x1E with bit 0 set to 1 clears the event bit. Writing it with bit 0 set to 0 leaves the event bit unchanged.
- R9: If statusByte changes in the same cycle as a clearing write to 0x1E, the event bit stays set.
- R10: The enable bit (bit 0 of 0x1F) is written directly with one byte. irqOut is high exactly when both the event bit and the enable bit are set, and clearing the enable bit does not clear the event bit.
- R11: The identifier reads as IDENT_VALUE at 0x02 (low byte) and 0x03 (high byte). The live status byte reads at 0x1C. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | 8 | Byte address |
| busWrData | input | 8 | Write data byte |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busRd | input | 1 | Read strobe, one cycle per byte |
| busRdData | output | 8 | Registered read data |
| liveWord | input | 32 | Live 32-bit hardware value |
| statusByte | input | 8 | Live status byte, source of the event |
| trimOut | output | 16 | Committed trim register |
| accumOut | output | 32 | Committed accumulator register |
| irqOut | output | 1 | Interrupt, event bit masked by enable |

## Verification
Read data comes from a single register stage, so each read result is due one cycle after its strobe. The bench samples it on the falling edge right after the capturing rising edge. Committed register values and the event bit also change on the rising edge that samples the strobe or the status change. They are checked at the falling edge that follows. The interrupt is a gate on two registered bits and so shares that timing. Sequence corner cases are driven with idle gaps and intruding accesses placed at exact cycles, and random words are compared with a bench model.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int ADDR_W    = 8;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 4;
  localparam int WORD_W    = MAX_BYTES * BYTE_W;
  localparam int IDX_W     = $clog2(MAX_BYTES);

  localparam int IDENT_BASE  = 2;
  localparam int IDENT_BYTES = 2;
  localparam int TRIM_BASE   = 8;
  localparam int TRIM_BYTES  = 2;
  localparam int ACCUM_BASE  = 12;
  localparam int ACCUM_BYTES = 4;
  localparam int LIVE_BASE   = 20;
  localparam int LIVE_BYTES  = 4;
  localparam int STAT_BASE   = 28;
  localparam int EVT_BASE    = 30;
  localparam int ENA_BASE    = 31;

  localparam int IDENT_W = IDENT_BYTES * BYTE_W;
  localparam int TRIM_W  = TRIM_BYTES * BYTE_W;
  localparam int ACCUM_W = ACCUM_BYTES * BYTE_W;

  localparam logic [ADDR_W-1:0] IDENT_LO = ADDR_W'(IDENT_BASE);
  localparam logic [ADDR_W-1:0] IDENT_HI = ADDR_W'(IDENT_BASE + IDENT_BYTES - 1);
  localparam logic [ADDR_W-1:0] TRIM_LO  = ADDR_W'(TRIM_BASE);
  localparam logic [ADDR_W-1:0] TRIM_HI  = ADDR_W'(TRIM_BASE + TRIM_BYTES - 1);
  localparam logic [ADDR_W-1:0] ACCUM_LO = ADDR_W'(ACCUM_BASE);
  localparam logic [ADDR_W-1:0] ACCUM_HI = ADDR_W'(ACCUM_BASE + ACCUM_BYTES - 1);
  localparam logic [ADDR_W-1:0] LIVE_LO  = ADDR_W'(LIVE_BASE);
  localparam logic [ADDR_W-1:0] LIVE_HI  = ADDR_W'(LIVE_BASE + LIVE_BYTES - 1);
  localparam logic [ADDR_W-1:0] STAT_A   = ADDR_W'(STAT_BASE);
  localparam logic [ADDR_W-1:0] EVT_A    = ADDR_W'(EVT_BASE);
  localparam logic [ADDR_W-1:0] ENA_A    = ADDR_W'(ENA_BASE);

  typedef enum logic [2:0] {
    REG_NONE, REG_IDENT, REG_TRIM, REG_ACCUM, REG_LIVE, REG_STAT, REG_EVT, REG_ENA
  } regId_t;

  typedef struct packed {
    regId_t           regSel;
    logic [IDX_W-1:0] idx;
    logic             multi;
    logic             last;
    logic             writable;
  } decode_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             rdEn;
    logic             snapLoad;
    logic             holdRead;
    logic             stageLoad;
    logic             commit;
    logic             evtClr;
    logic             enaWr;
    regId_t           target;
    logic [IDX_W-1:0] idx;
  } ctrlStrobes_t;

  function automatic decode_t decodeAddr(input logic [ADDR_W-1:0] a);
    decode_t d;
    d = '0;
    if (a >= IDENT_LO && a <= IDENT_HI) begin
      d.regSel = REG_IDENT; d.multi = 1'b1;
      d.idx = IDX_W'(a - IDENT_LO); d.last = (a == IDENT_HI);
    end else if (a >= TRIM_LO && a <= TRIM_HI) begin
      d.regSel = REG_TRIM; d.multi = 1'b1; d.writable = 1'b1;
      d.idx = IDX_W'(a - TRIM_LO); d.last = (a == TRIM_HI);
    end else if (a >= ACCUM_LO && a <= ACCUM_HI) begin
      d.regSel = REG_ACCUM; d.multi = 1'b1; d.writable = 1'b1;
      d.idx = IDX_W'(a - ACCUM_LO); d.last = (a == ACCUM_HI);
    end else if (a >= LIVE_LO && a <= LIVE_HI) begin
      d.regSel = REG_LIVE; d.multi = 1'b1;
      d.idx = IDX_W'(a - LIVE_LO); d.last = (a == LIVE_HI);
    end else if (a == STAT_A) begin
      d.regSel = REG_STAT; d.last = 1'b1;
    end else if (a == EVT_A) begin
      d.regSel = REG_EVT; d.last = 1'b1;
    end else if (a == ENA_A) begin
      d.regSel = REG_ENA; d.last = 1'b1;
    end
    return d;
  endfunction
endpackage

// File: rtl/mbr_ctrl.sv
module mbr_ctrl
  import mbr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output ctrlStrobes_t      st
);
  decode_t dec;
  assign dec = decodeAddr(busAddr);

  logic             rdPend, wrPend, nRdPend, nWrPend;
  regId_t           rdReg, wrReg, nRdReg, nWrReg;
  logic [IDX_W-1:0] rdNext, wrNext, nRdNext, nWrNext;

  always_comb begin
    st        = '0;
    st.target = dec.regSel;
    st.idx    = dec.idx;
    nRdPend = rdPend; nRdReg = rdReg; nRdNext = rdNext;
    nWrPend = wrPend; nWrReg = wrReg; nWrNext = wrNext;
    if (busWr) begin
      nRdPend = 1'b0;
      if (dec.writable && dec.idx == '0) begin
        st.stageLoad = 1'b1;
        nWrPend = 1'b1; nWrReg = dec.regSel; nWrNext = IDX_W'(1);
      end else if (wrPend && dec.writable && dec.regSel == wrReg && dec.idx == wrNext) begin
        if (dec.last) begin
          st.commit = 1'b1;
          nWrPend   = 1'b0;
        end else begin
          st.stageLoad = 1'b1;
          nWrNext      = wrNext + 1'b1;
        end
      end else begin
        nWrPend   = 1'b0;
        st.evtClr = (dec.regSel == REG_EVT);
        st.enaWr  = (dec.regSel == REG_ENA);
      end
    end else if (busRd) begin
      nWrPend = 1'b0;
      st.rdEn = 1'b1;
      if (dec.multi && dec.idx == '0) begin
        st.snapLoad = 1'b1;
        nRdPend = 1'b1; nRdReg = dec.regSel; nRdNext = IDX_W'(1);
      end else if (rdPend && dec.multi && dec.regSel == rdReg && dec.idx == rdNext) begin
        st.holdRead = 1'b1;
        if (dec.last) nRdPend = 1'b0;
        else          nRdNext = rdNext + 1'b1;
      end else begin
        nRdPend = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend <= 1'b0; rdReg <= REG_NONE; rdNext <= '0;
      wrPend <= 1'b0; wrReg <= REG_NONE; wrNext <= '0;
    end else begin
      rdPend <= nRdPend; rdReg <= nRdReg; rdNext <= nRdNext;
      wrPend <= nWrPend; wrReg <= nWrReg; wrNext <= nWrNext;
    end
  end

  // R5
  pend_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(rdPend && wrPend));
  // R4
  commit_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> (wrPend && wrReg == st.target));
  // R3
  rd_abort_chk: assert property (@(posedge clk) disable iff (!rstN) busWr |=> !rdPend);
endmodule

// File: rtl/mbr_datapath.sv
module mbr_datapath
  import mbr_pkg::*;
#(
  parameter logic [IDENT_W-1:0] IDENT_VALUE = 16'hC0DE
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       st,
  input  logic [BYTE_W-1:0]  busWrData,
  input  logic [WORD_W-1:0]  liveWord,
  input  logic [BYTE_W-1:0]  statusByte,
  output logic [BYTE_W-1:0]  rdData,
  output logic [TRIM_W-1:0]  trimReg,
  output logic [ACCUM_W-1:0] accReg,
  output logic               irqOut
);
  logic [WORD_W-1:0] holdReg, stageReg, liveVal, commitVal;
  logic [BYTE_W-1:0] prevStatus, rdByte;
  logic              evtBit, enaBit, statusChg;
  logic [IDX_W+2:0]  byteSel;

  assign byteSel   = {st.idx, 3'b000};
  assign statusChg = (statusByte != prevStatus);
  assign irqOut    = evtBit & enaBit;

  always_comb begin
    case (st.target)
      REG_IDENT: liveVal = WORD_W'(IDENT_VALUE);
      REG_TRIM:  liveVal = WORD_W'(trimReg);
      REG_ACCUM: liveVal = WORD_W'(accReg);
      REG_LIVE:  liveVal = liveWord;
      REG_STAT:  liveVal = WORD_W'(statusByte);
      REG_EVT:   liveVal = WORD_W'(evtBit);
      REG_ENA:   liveVal = WORD_W'(enaBit);
      default:   liveVal = '0;
    endcase
    rdByte = st.holdRead ? holdReg[byteSel +: BYTE_W] : liveVal[byteSel +: BYTE_W];
    commitVal = stageReg;
    commitVal[byteSel +: BYTE_W] = busWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg    <= '0;
      stageReg   <= '0;
      trimReg    <= '0;
      accReg     <= '0;
      evtBit     <= 1'b0;
      enaBit     <= 1'b0;
      rdData     <= '0;
      prevStatus <= statusByte;
    end else begin
      prevStatus <= statusByte;
      if (st.snapLoad)  holdReg <= liveVal;
      if (st.stageLoad) stageReg[byteSel +: BYTE_W] <= busWrData;
      if (st.commit && st.target == REG_TRIM)  trimReg <= commitVal[TRIM_W-1:0];
      if (st.commit && st.target == REG_ACCUM) accReg  <= commitVal[ACCUM_W-1:0];
      if (st.enaWr) enaBit <= busWrData[0];
      evtBit <= (evtBit & ~(st.evtClr & busWrData[0])) | statusChg;
      if (st.rdEn) rdData <= rdByte;
    end
  end

  // R4
  trim_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(st.commit && st.target == REG_TRIM) |=> $stable(trimReg));
  // R2
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.snapLoad |=> $stable(holdReg));
  // R9
  evt_set_chk: assert property (@(posedge clk) disable iff (!rstN) statusChg |=> evtBit);
endmodule

// File: rtl/mbr_coherency_unit.sv
module mbr_coherency_unit
  import mbr_pkg::*;
#(
  parameter logic [IDENT_W-1:0] IDENT_VALUE = 16'hC0DE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BYTE_W-1:0]  busWrData,
  input  logic               busWr,
  input  logic               busRd,
  output logic [BYTE_W-1:0]  busRdData,
  input  logic [WORD_W-1:0]  liveWord,
  input  logic [BYTE_W-1:0]  statusByte,
  output logic [TRIM_W-1:0]  trimOut,
  output logic [ACCUM_W-1:0] accumOut,
  output logic               irqOut
);
  ctrlStrobes_t strobes;

  mbr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .st      (strobes)
  );

  mbr_datapath #(.IDENT_VALUE(IDENT_VALUE)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (strobes),
    .busWrData  (busWrData),
    .liveWord   (liveWord),
    .statusByte (statusByte),
    .rdData     (busRdData),
    .trimReg    (trimOut),
    .accReg     (accumOut),
    .irqOut     (irqOut)
  );
endmodule

// File: tb/mbr_coherency_unit_bench.sv
module mbr_coherency_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0, busWrData = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busRdData;
  logic [31:0] liveWord = '0;
  logic [7:0]  statusByte = '0;
  logic [15:0] trimOut;
  logic [31:0] accumOut;
  logic        irqOut;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] expTrim = '0;
  logic [31:0] expAcc = '0;

  always #5 clk = ~clk;

  mbr_coherency_unit u_mbr_coherency_unit (.*);

  function automatic logic [7:0] byteOf(input logic [31:0] w, input int i);
    return w[i*8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; d = busRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [7:0] d;
    logic [31:0] a, b;
    void'($urandom(32'd7341));
    idle(3);
    @(negedge clk); rstN = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 trimOut", trimOut, 0);
    chk("R1 accumOut", accumOut, 0);
    chk("R1 irqOut", irqOut, 0);
    rd(8'h1E, d); chk("R1 event bit", d, 0);
    rd(8'h1F, d); chk("R1 enable bit", d, 0);

    // R11 identifier, status byte, unmapped
    rd(8'h02, d); chk("R11 ident low", d, 8'hDE);
    rd(8'h03, d); chk("R11 ident high", d, 8'hC0);
    rd(8'h40, d); chk("R11 unmapped", d, 0);

    // R6 read data due exactly one cycle after strobe, held afterwards
    @(negedge clk); busAddr = 8'h03; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; busAddr = 8'h00;
    chk("R6 data next cycle", busRdData, 8'hC0);
    idle(2); chk("R6 data held", busRdData, 8'hC0);

    // R4 trim staged with idle gap, commit on top byte
    wr(8'h08, 8'h34); idle(5);
    chk("R4 trim before top byte", trimOut, 0);
    wr(8'h09, 8'h12); expTrim = 16'h1234;
    chk("R4 trim committed", trimOut, expTrim);

    // R5 upper byte write alone ignored
    wr(8'h09, 8'hFF);
    chk("R5 lone upper write", trimOut, expTrim);

    // R5 out-of-order accumulator write dropped
    wr(8'h0C, 8'h11); wr(8'h0E, 8'h33); wr(8'h0F, 8'h44);
    chk("R5 out of order accum", accumOut, 0);
    // R5 interleaved read drops staging
    wr(8'h08, 8'hAA); rd(8'h1C, d); wr(8'h09, 8'hBB);
    chk("R5 read between trim bytes", trimOut, expTrim);

    // R2 snapshot of live word
    liveWord = 32'hA1B2C3D4;
    rd(8'h14, d); chk("R2 live lsb", d, 8'hD4);
    liveWord = 32'h55667788;
    rd(8'h15, d); chk("R2 held byte1", d, 8'hC3);
    rd(8'h16, d); chk("R2 held byte2", d, 8'hB2);
    rd(8'h17, d); chk("R2 held byte3", d, 8'hA1);

    // R3 intervening access breaks sequence
    rd(8'h14, d);
    liveWord = 32'h0F1E2D3C;
    rd(8'h1C, d);
    rd(8'h15, d); chk("R3 after intervening read", d, 8'h2D);
    rd(8'h17, d); chk("R3 lone upper read", d, 8'h0F);
    rd(8'h14, d); wr(8'h40, 8'h00);
    liveWord = 32'h99999999;
    rd(8'h15, d); chk("R3 after intervening write", d, 8'h99);

    // R7 event on status change, masked
    @(negedge clk); statusByte = 8'h05;
    @(negedge clk);
    chk("R10 irq masked", irqOut, 0);
    rd(8'h1E, d); chk("R7 event latched", d, 1);
    // R10 enable
    wr(8'h1F, 8'h01);
    chk("R10 irq enabled", irqOut, 1);
    // R8 write zero keeps event
    wr(8'h1E, 8'h00);
    chk("R8 zero write keeps event", irqOut, 1);
    wr(8'h1F, 8'h00);
    chk("R10 mask drops irq", irqOut, 0);
    rd(8'h1E, d); chk("R10 event kept under mask", d, 1);
    wr(8'h1F, 8'h01);
    wr(8'h1E, 8'h01);
    chk("R8 one write clears", irqOut, 0);

    // R9 coincident change and clear
    @(negedge clk); statusByte = 8'h06; busAddr = 8'h1E; busWrData = 8'h01; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
    chk("R9 coincident keeps event", irqOut, 1);
    wr(8'h1E, 8'h01);
    chk("R8 clear after coincident", irqOut, 0);
    rd(8'h1C, d); chk("R11 status byte", d, 8'h06);

    // Random accumulator writes with gaps and aborts, and live snapshots
    for (int it = 0; it < 50; it++) begin
      logic [31:0] v;
      bit abortIt;
      v = $urandom;
      abortIt = ($urandom % 4) == 0;
      wr(8'h0C, byteOf(v, 0)); idle($urandom % 3);
      wr(8'h0D, byteOf(v, 1));
      if (abortIt) wr(8'h1F, 8'h01);
      wr(8'h0E, byteOf(v, 2)); idle($urandom % 3);
      chk("R4 accum before top byte", accumOut, expAcc);
      wr(8'h0F, byteOf(v, 3));
      if (!abortIt) expAcc = v;
      chk(abortIt ? "R5 aborted accum" : "R4 accum committed", accumOut, expAcc);
      for (int i = 0; i < 4; i++) begin
        rd(8'h0C + 8'(i), d); chk("R2 accum readback", d, byteOf(expAcc, i));
      end
      a = $urandom; b = $urandom;
      liveWord = a;
      rd(8'h14, d); chk("R2 random lsb", d, byteOf(a, 0));
      liveWord = b;
      for (int i = 1; i < 4; i++) begin
        rd(8'h14 + 8'(i), d); chk("R2 random held", d, byteOf(a, i));
      end
    end

    finishRun();
  end
endmodule